// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Watermark

This block sits between a byte-serial bus engine and the processor-side register port of a serial controller. It holds two first-in first-out queues of equal depth. The transmit queue is loaded by software and drained by the engine. Each transmit entry is a data byte plus two framing flags, one that asks the engine for a start condition and one that asks for a stop condition. The receive queue is filled by the engine one byte at a time and emptied by software reads.

Software sees the queues through a small register port. It can read a status byte with full and empty flags for both queues. It can read occupancy registers that report the number of stored entries minus one. It can set a receive watermark that is programmed as the threshold minus one, and it can flush the transmit queue through a control bit. Three level interrupt sources follow the queue fill levels: receive level, transmit empty and transmit half-empty. The bus engine is represented by a pop strobe on the transmit side and a push strobe on the receive side.

Top module: `ser_fifo_pair`

## Requirements
- R1: Each queue holds DEPTH (16) entries. A push into a full queue is ignored and leaves its contents and count unchanged. This applies to a transmit-data write and to `rx_push`, even when a pop happens in the same cycle.
- R2: A pop from an empty queue is ignored. `tx_pop` with no entry leaves the transmit queue empty. A receive-data read with no entry returns 0 and removes nothing.
- R3: The occupancy registers (address 4 transmit, address 5 receive) read the stored entry count minus one. With nothing stored they read 0.
- R4: The status register (address 1) has bit 4 = transmit full, bit 5 = receive full, bit 6 = receive empty and bit 7 = transmit empty. All its other bits read 0.
- R5: A read of the receive-data register (address 3, `reg_rd` high) returns the oldest byte and removes exactly that one byte. Bytes leave in arrival order.
- R6: A write to the control register (address 0) with bit 1 set empties the transmit queue at the next edge. This takes priority over a pop in the same cycle. The control register reads 0.
- R7: A write to address 2 with `reg_wr_wide` high stores `reg_wdata[9:0]`, with bit 8 = start flag and bit 9 = stop flag. With `reg_wr_wide` low, the write stores `reg_wdata[7:0]` with both flags 0. `tx_valid` is high while an entry is stored, and `tx_entry` shows the oldest entry.
- R8: The watermark register (address 6, 4 bits, reset value 15) is readable and writable. `irq_rx_level` is high exactly when the receive count is at least the watermark plus one.
- R9: `irq_tx_empty` is high exactly when the transmit queue is empty. `irq_tx_half` is high exactly when it holds DEPTH/2 (8) or fewer entries.
- R10: Reset is synchronous and active low. It leaves both queues empty, so the status register reads 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_wide | input | 1 | Transmit write carries the two flag bits |
| reg_rd | input | 1 | Register read strobe (pops on receive-data address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 10 | Write data (bits 9:8 used only by wide transmit writes) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_pop | input | 1 | Engine takes the oldest transmit entry |
| tx_valid | output | 1 | Transmit queue holds at least one entry |
| tx_entry | output | 10 | Oldest transmit entry: {stop, start, data} |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| irq_rx_level | output | 1 | Receive count reached watermark plus one |
| irq_tx_empty | output | 1 | Transmit queue empty |
| irq_tx_half | output | 1 | Transmit queue at most half full |

## Verification
The bench builds the block with its default parameters: DEPTH 16 and an 8-bit data path. At this size both queues can be filled past full, drained past empty and wrapped several times within a short run. It also places the watermark at the bottom (0) and the top (15) of its range and takes the half-empty source through its 8/9 boundary. Simultaneous push and pop on a full transmit queue and a flush that coincides with a pop are driven deliberately, because those cases separate a correct priority order from a plausible wrong one.

// File: rtl/sfp_pkg.sv
// Package: shared register addresses, bit positions and entry layout
// for the transmit/receive FIFO pair. Assumes an 8-bit data path.
package sfp_pkg;
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_TXD   = 3'd2;
    localparam logic [2:0] A_RXD   = 3'd3;
    localparam logic [2:0] A_TXOCC = 3'd4;
    localparam logic [2:0] A_RXOCC = 3'd5;
    localparam logic [2:0] A_RXWM  = 3'd6;

    localparam int FLUSH_BIT   = 1;
    localparam int ST_TX_FULL  = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_RX_EMPTY = 6;
    localparam int ST_TX_EMPTY = 7;

    typedef struct packed {
        logic       stop;
        logic       start;
        logic [7:0] data;
    } tx_entry_t;
endpackage

// File: rtl/sfp_fifo.sv
// Module: sfp_fifo
// Generic synchronous FIFO with an exact entry count.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are dropped without touching any pointer. Flush clears
// everything and wins over push and pop in the same cycle.
module sfp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    // Qualify strobes against the current fill level
    always_comb begin
        do_push = push && (count != CW'(DEPTH));
        do_pop  = pop  && (count != '0);
    end

    // Storage write; entries need no reset
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/sfp_regs.sv
// Module: sfp_regs
// Register decode for the FIFO pair: turns port strobes into FIFO
// push/pop/flush, holds the receive watermark and builds read data.
// Assumes an 8-bit data path (status bit positions are fixed).
module sfp_regs
    import sfp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wr_wide,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W+1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CW-1:0]     tx_count,
    input  logic [CW-1:0]     rx_count,
    input  logic [DATA_W-1:0] rx_head,
    output logic              tx_push,
    output logic [DATA_W+1:0] tx_din,
    output logic              tx_flush,
    output logic              rx_pop,
    output logic [AW-1:0]     rx_wm
);
    // Zero-based occupancy: count minus one, floored at zero
    function automatic logic [DATA_W-1:0] occ(input logic [CW-1:0] c);
        logic [CW-1:0] m;
        m = (c == '0) ? '0 : c - 1'b1;
        return DATA_W'(m[AW-1:0]);
    endfunction

    // Decode write and read strobes into FIFO controls
    always_comb begin
        tx_push  = reg_wr && (reg_addr == A_TXD);
        tx_flush = reg_wr && (reg_addr == A_CTRL) && reg_wdata[FLUSH_BIT];
        rx_pop   = reg_rd && (reg_addr == A_RXD);
        tx_din   = reg_wr_wide ? reg_wdata
                               : {2'b00, reg_wdata[DATA_W-1:0]};
    end

    // Receive watermark register, resets to the top of the range
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_wm <= AW'(DEPTH - 1);
        else if (reg_wr && (reg_addr == A_RXWM))
            rx_wm <= reg_wdata[AW-1:0];
    end

    // Read-data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT: begin
                reg_rdata[ST_TX_FULL]  = (tx_count == CW'(DEPTH));
                reg_rdata[ST_RX_FULL]  = (rx_count == CW'(DEPTH));
                reg_rdata[ST_RX_EMPTY] = (rx_count == '0);
                reg_rdata[ST_TX_EMPTY] = (tx_count == '0);
            end
            A_RXD:   reg_rdata = (rx_count != '0) ? rx_head : '0;
            A_TXOCC: reg_rdata = occ(tx_count);
            A_RXOCC: reg_rdata = occ(rx_count);
            A_RXWM:  reg_rdata = DATA_W'(rx_wm);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_fifo_pair.sv
// Module: ser_fifo_pair (top)
// Transmit and receive FIFOs for a byte-serial controller with a
// register view and level interrupt sources. The bus engine is
// outside: it pops transmit entries and pushes received bytes.
module ser_fifo_pair #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int TXW   = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wr_wide,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [TXW-1:0]    reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_pop,
    output logic              tx_valid,
    output logic [TXW-1:0]    tx_entry,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              irq_rx_level,
    output logic              irq_tx_empty,
    output logic              irq_tx_half
);
    logic [CW-1:0]     tx_count, rx_count;
    logic [DATA_W-1:0] rx_head;
    logic [TXW-1:0]    tx_din;
    logic              tx_push, tx_flush, rx_pop;
    logic [AW-1:0]     rx_wm;

    sfp_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wr_wide(reg_wr_wide), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_count(tx_count), .rx_count(rx_count), .rx_head(rx_head),
        .tx_push(tx_push), .tx_din(tx_din), .tx_flush(tx_flush),
        .rx_pop(rx_pop), .rx_wm(rx_wm)
    );

    sfp_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_entry), .count(tx_count)
    );

    sfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rx_head), .count(rx_count)
    );

    // Level interrupt sources and engine-side valid
    always_comb begin
        tx_valid     = (tx_count != '0);
        irq_tx_empty = (tx_count == '0);
        irq_tx_half  = (tx_count <= CW'(DEPTH / 2));
        irq_rx_level = (rx_count > CW'(rx_wm));
    end
endmodule

// File: rtl/sfp_chk.sv
// Module: sfp_chk
// Property checker for ser_fifo_pair, attached by bind below. Sees the
// port strobes and the two internal entry counts.
module sfp_chk
    import sfp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic [9:0]    reg_wdata,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          tx_valid,
    input logic          irq_tx_empty,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    // R1
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));
    // R1
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH) && rx_push && !(reg_rd && reg_addr == A_RXD))
        |=> rx_count == CW'(DEPTH));
    // R2
    tx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && tx_pop && !(reg_wr && reg_addr == A_TXD))
        |=> tx_count == '0);
    // R5
    rx_pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RXD && rx_count != '0 && !rx_push)
        |=> rx_count == $past(rx_count) - 1'b1);
    // R6
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[FLUSH_BIT])
        |=> tx_count == '0);
    // R9
    tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> !tx_valid);
endmodule

bind ser_fifo_pair sfp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tx_pop(tx_pop),
    .rx_push(rx_push), .tx_valid(tx_valid), .irq_tx_empty(irq_tx_empty),
    .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/sim_ser_fifo_pair.sv
// Bench: behavioural queue model updated on every rising edge and
// compared against the outputs at every falling edge.
module sim_ser_fifo_pair;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr = 0, reg_wr_wide = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [9:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       tx_pop = 0, tx_valid;
    logic [9:0] tx_entry;
    logic       rx_push = 0;
    logic [7:0] rx_byte = 0;
    logic       irq_rx_level, irq_tx_empty, irq_tx_half;

    int n_chk = 0, n_fail = 0;
    logic [9:0] txq[$];
    logic [7:0] rxq[$];
    int wm = 15;

    always #2.5 clk = ~clk;

    ser_fifo_pair u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Model: apply the strobes present at this rising edge
    task automatic model_edge();
        int tsz = txq.size();
        int rsz = rxq.size();
        if (!rst_n) begin
            txq.delete(); rxq.delete(); wm = 15;
            return;
        end
        if (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) txq.delete();
        else begin
            if (tx_pop && tsz > 0) void'(txq.pop_front());
            if (reg_wr && reg_addr == 3'd2 && tsz < 16)
                txq.push_back(reg_wr_wide ? reg_wdata : {2'b00, reg_wdata[7:0]});
        end
        if (reg_rd && reg_addr == 3'd3 && rsz > 0) void'(rxq.pop_front());
        if (rx_push && rsz < 16) rxq.push_back(rx_byte);
        if (reg_wr && reg_addr == 3'd6) wm = int'(reg_wdata[3:0]);
    endtask

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd1: return {txq.size() == 0, rxq.size() == 0,
                          rxq.size() == 16, txq.size() == 16, 4'b0};
            3'd3: return rxq.size() ? rxq[0] : 8'h00;
            3'd4: return txq.size() ? 8'(txq.size() - 1) : 8'h00;
            3'd5: return rxq.size() ? 8'(rxq.size() - 1) : 8'h00;
            3'd6: return 8'(wm);
            default: return 8'h00;
        endcase
    endfunction

    // One clock: model at the edge, compare outputs at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        reg_wr = 0; reg_wr_wide = 0; reg_rd = 0; tx_pop = 0; rx_push = 0;
        chk("R7 tx_valid", tx_valid, txq.size() > 0);
        if (txq.size() > 0) chk("R7 tx_entry", tx_entry, txq[0]);
        chk("R9 irq_tx_empty", irq_tx_empty, txq.size() == 0);
        chk("R9 irq_tx_half", irq_tx_half, txq.size() <= 8);
        chk("R8 irq_rx_level", irq_rx_level, rxq.size() >= wm + 1);
    endtask

    task automatic wr(logic [2:0] a, logic [9:0] d, logic wide);
        reg_wr = 1; reg_addr = a; reg_wdata = d; reg_wr_wide = wide;
        step();
    endtask

    task automatic rd(string tag, logic [2:0] a);
        reg_rd = 1; reg_addr = a;
        #1 chk(tag, reg_rdata, exp_rd(a));
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R10 reset state
        reg_addr = 3'd1; #1 chk("R10 status after reset", reg_rdata, 8'hC0);
        rd("R3 tx occupancy empty", 3'd4);
        rd("R3 rx occupancy empty", 3'd5);
        reg_addr = 3'd6; #1 chk("R8 watermark reset", reg_rdata, 8'd15);
        // R2 pop from empty transmit queue
        tx_pop = 1; step();
        rd("R2 tx occupancy after empty pop", 3'd4);
        // R7 narrow and wide writes
        wr(3'd2, 10'h3A5, 1'b0);
        chk("R7 narrow write clears flags", tx_entry, 10'h0A5);
        rd("R3 one entry reads 0", 3'd4);
        wr(3'd2, 10'h13C, 1'b1);
        wr(3'd2, 10'h277, 1'b1);
        // R1 fill transmit queue past full
        for (int i = 0; i < 16; i++) wr(3'd2, 10'(i * 37), 1'b1);
        rd("R4 tx full status", 3'd1);
        rd("R3 tx occupancy full", 3'd4);
        reg_addr = 3'd1; #1 chk("R4 status bit 4", reg_rdata, 8'h50);
        // R1 push and pop together while full: push dropped
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = 10'h1FF; tx_pop = 1; step();
        rd("R1 tx occupancy after full push+pop", 3'd4);
        // drain through the half boundary and past empty
        for (int i = 0; i < 18; i++) begin tx_pop = 1; step(); end
        rd("R2 tx empty after overdrain", 3'd1);
        // R6 flush with a coincident pop
        for (int i = 0; i < 5; i++) wr(3'd2, 10'(i + 1), 1'b0);
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = 10'h002; tx_pop = 1; step();
        chk("R6 flush empties tx", tx_valid, 1'b0);
        rd("R6 control reads 0", 3'd0);
        wr(3'd0, 10'h001, 1'b0);
        rd("R6 write without bit 1 keeps empty", 3'd4);
        // R8 watermark 3: level at 4 bytes
        wr(3'd6, 10'h003, 1'b0);
        rd("R8 watermark readback", 3'd6);
        for (int i = 0; i < 4; i++) begin
            rx_push = 1; rx_byte = 8'(8'hC0 + i); step();
        end
        chk("R8 level at wm+1", irq_rx_level, 1'b1);
        rd("R5 first byte", 3'd3);
        chk("R8 level drops below", irq_rx_level, 1'b0);
        rd("R3 rx occupancy", 3'd5);
        // R1 fill receive queue past full
        for (int i = 0; i < 20; i++) begin
            rx_push = 1; rx_byte = 8'(i * 11 + 3); step();
        end
        rd("R4 rx full status", 3'd1);
        wr(3'd6, 10'h000, 1'b0);
        // R5 read all, then read from empty (R2)
        for (int i = 0; i < 18; i++) rd("R5 rx data order", 3'd3);
        rd("R2 rx read empty", 3'd3);
        rd("R4 both empty", 3'd1);
        // push and read together
        rx_push = 1; rx_byte = 8'h5A; step();
        rx_push = 1; rx_byte = 8'h5B; reg_rd = 1; reg_addr = 3'd3; step();
        rd("R5 combined push/read", 3'd3);
        wr(3'd6, 10'h00F, 1'b0);
        for (int i = 0; i < 16; i++) begin rx_push = 1; rx_byte = 8'(i); step(); end
        chk("R8 level at watermark 15", irq_rx_level, 1'b1);
        rd("R3 rx occupancy full", 3'd5);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule